// File: doc/BRIEF.md
# Majority-Vote Serial Character Receiver

This block recovers asynchronous serial characters from one receive line. The line is brought into the clock domain through a short synchronizer, and a falling edge arms the receiver. Bit timing comes from an oversampling enable pulse that runs at sixteen times the bit rate. The receiver confirms the start bit at its centre, then takes eight data bits, least significant first, and finally the stop bit. Each bit is settled by a two-of-three vote over samples near its centre, so one corrupted sample cannot change the result.

Each finished character goes into a two-entry queue together with a framing-error flag that records whether the stop bit was low. The consumer reads the queue through a valid/ready output stream. It can apply back-pressure at any time by holding ready low. While back-pressure is applied, the head entry stays on the outputs unchanged and newer characters wait behind it. A character that arrives when both entries are occupied is discarded and a sticky overrun flag is raised.

A level interrupt output mirrors queue occupancy. Two enables, a port enable and a receive enable, must both be high for the line to be watched.

Top module: `uart_rx_mv`

## Requirements
- R1: After reset, out_valid, rx_irq and overrun are all 0.
- R2: With both enables high, a 1-to-0 change of the synchronized line starts a character. The start bit is voted with the same three-sample rule as the data bits. If the start-bit vote is 1, the character is abandoned without an entry and without any flag, and the receiver waits for the next falling edge.
- R3: Ticks are counted within each bit period. The count is 0 at the first tick after the edge is detected and wraps after 15. Each bit is decided by majority over the line samples taken at counts 7, 8 and 9. Eight data bits follow the start bit, least significant first, so a single disturbed sample in any bit leaves the character unchanged.
- R4: The stop bit is voted the same way. A vote of 0 stores the character with out_ferr = 1, and a vote of 1 stores it with out_ferr = 0.
- R5: The character is stored on the stop bit's count-9 tick. With tick held high and an empty queue, if rx is first driven low just after clock edge E0, out_valid is 0 after edge E156 and 1 after edge E157.
- R6: rx_irq and out_valid are 1 exactly while the queue holds at least one character.
- R7: An entry leaves the queue on a clock edge where out_valid and out_ready are both 1. Entries leave oldest first. While out_valid is 1 and out_ready is 0, out_data and out_ferr hold steady.
- R8: The queue holds 2 characters. A character completed while the queue is full, with no removal on the same edge, is dropped, and overrun becomes 1.
- R9: Once set, overrun stays 1 until recv_en is 0 at a clock edge, which clears it on that edge. A low port_en alone does not clear it.
- R10: While port_en or recv_en is 0, line activity is ignored and any character in progress is abandoned. Characters already queued stay readable.
- R11: The bit counters advance only on cycles with tick = 1. With tick pulsing every third clock, characters sent at 48 clocks per bit are received correctly. With tick held at 0, no character completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| recv_en | input | 1 | Receive enable; low also clears overrun |
| tick | input | 1 | Oversampling enable, 16 per bit time |
| rx | input | 1 | Asynchronous serial line, idle high |
| out_valid | output | 1 | Head-of-queue character is present |
| out_ready | input | 1 | Consumer accepts the head character |
| out_data | output | 8 | Head character data |
| out_ferr | output | 1 | Framing error of the head character |
| rx_irq | output | 1 | Level interrupt, high while the queue is not empty |
| overrun | output | 1 | Sticky flag for a character dropped on a full queue |

## Verification
With tick high every cycle, a character is stored 157 edges after the edge following which the line first fell. This delay is made up of two synchronizer stages, one edge-detect register, and 154 tick counts. The bench checks out_valid just before and just after that edge. A removal shows one edge after ready is seen high, and clearing overrun shows one edge after recv_en is seen low. The bench drives every input 1 ns after a rising edge and reads outputs in that same slot, so each check falls between edges. False-start, glitch and back-pressure cases are placed at sample counts derived from the same arithmetic.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic line,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b1;
        else        chain[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b1;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];
  end

  assign line = chain[STAGES-1];
  assign fall = prev & ~chain[STAGES-1];

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              line,
  input  logic              fall,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              push_ferr,
  output logic              busy
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] SMP_A = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] SMP_B = CNT_W'(OVS / 2);
  localparam logic [CNT_W-1:0] SMP_C = CNT_W'(OVS / 2 + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic              smp_a;
  logic              smp_b;
  logic [DATA_W-1:0] shreg;
  logic              vote;
  logic              at_c;

  assign vote      = vote3(smp_a, smp_b, line);
  assign at_c      = tick && (cnt == SMP_C);
  assign push      = en && (state == RX_STOP) && at_c;
  assign push_data = shreg;
  assign push_ferr = ~vote;
  assign busy      = (state != RX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      cnt   <= '0;
      idx   <= '0;
      smp_a <= 1'b1;
      smp_b <= 1'b1;
      shreg <= '0;
    end else if (!en) begin
      state <= RX_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        RX_IDLE: begin
          if (fall) begin
            state <= RX_START;
            cnt   <= '0;
            idx   <= '0;
          end
        end
        default: begin
          if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (cnt == SMP_A) smp_a <= line;
            if (cnt == SMP_B) smp_b <= line;
            if (cnt == SMP_C) begin
              if (state == RX_START && vote) state <= RX_IDLE;
              if (state == RX_DATA) shreg <= {vote, shreg[DATA_W-1:1]};
              if (state == RX_STOP) state <= RX_IDLE;
            end
            if (cnt == LAST) begin
              if (state == RX_START) begin
                state <= RX_DATA;
              end else if (state == RX_DATA) begin
                if (idx == IDX_LAST) state <= RX_STOP;
                else                 idx   <= idx + 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 2,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic             not_empty,
  output logic             drop,
  output logic [LVL_W-1:0] level
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr;
  logic [PTR_W-1:0] rptr;
  logic             full;
  logic             do_pop;
  logic             do_push;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (level == LVL_W'(DEPTH));
  assign not_empty = (level != '0);
  assign do_pop    = pop && not_empty;
  assign do_push   = push && (!full || do_pop);
  assign drop      = push && !do_push;
  assign rdata     = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
    end
  end

endmodule

// File: rtl/uart_rx_mv.sv
module uart_rx_mv #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int FIFO_DEPTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              recv_en,
  input  logic              tick,
  input  logic              rx,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_ferr,
  output logic              rx_irq,
  output logic              overrun
);

  localparam int ENT_W = DATA_W + 1;
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  logic              rx_en;
  logic              line;
  logic              line_fall;
  logic              frm_push;
  logic [DATA_W-1:0] frm_data;
  logic              frm_ferr;
  logic              frm_busy;
  logic [ENT_W-1:0]  head;
  logic              fifo_nempty;
  logic              fifo_drop;
  logic [LVL_W-1:0]  fifo_level;
  logic              ovr_q;

  assign rx_en = port_en & recv_en;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (rx),
    .line  (line),
    .fall  (line_fall)
  );

  uart_rx_framer #(.DATA_W(DATA_W), .OVS(OVS)) i_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (rx_en),
    .tick      (tick),
    .line      (line),
    .fall      (line_fall),
    .push      (frm_push),
    .push_data (frm_data),
    .push_ferr (frm_ferr),
    .busy      (frm_busy)
  );

  uart_rx_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) i_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (frm_push),
    .wdata     ({frm_ferr, frm_data}),
    .pop       (out_ready),
    .rdata     (head),
    .not_empty (fifo_nempty),
    .drop      (fifo_drop),
    .level     (fifo_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovr_q <= 1'b0;
    else if (!recv_en)  ovr_q <= 1'b0;
    else if (fifo_drop) ovr_q <= 1'b1;
  end

  assign out_valid = fifo_nempty;
  assign rx_irq    = fifo_nempty;
  assign out_data  = head[DATA_W-1:0];
  assign out_ferr  = head[DATA_W];
  assign overrun   = ovr_q;

endmodule

// File: rtl/uart_rx_mv_chk.sv
module uart_rx_mv_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  parameter int LVL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_en,
  input logic              recv_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ferr,
  input logic              rx_irq,
  input logic              overrun,
  input logic              push,
  input logic              drop,
  input logic              busy,
  input logic [LVL_W-1:0]  level
);

  a_r7_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ferr));

  a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  a_r8_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(drop));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !recv_en |=> !overrun);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && recv_en |=> overrun);

  a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_en && recv_en) |=> !busy && !push);

  a_r6_irq_on_push: assert property (@(posedge clk) disable iff (!rst_n)
    push && (level == '0) |=> rx_irq);

  a_r5_idle_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !busy);

endmodule

bind uart_rx_mv uart_rx_mv_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (FIFO_DEPTH),
  .LVL_W  (LVL_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .port_en   (port_en),
  .recv_en   (recv_en),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_ferr  (out_ferr),
  .rx_irq    (rx_irq),
  .overrun   (overrun),
  .push      (frm_push),
  .drop      (fifo_drop),
  .busy      (frm_busy),
  .level     (fifo_level)
);

// File: tb/test_uart_rx_mv.sv
`timescale 1ns/1ps
module test_uart_rx_mv;

  localparam int DW  = 8;
  localparam int OVS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_en = 1'b0;
  logic recv_en = 1'b0;
  logic tick = 1'b0;
  logic rx = 1'b1;
  logic out_ready = 1'b0;
  logic out_valid;
  logic [DW-1:0] out_data;
  logic out_ferr;
  logic rx_irq;
  logic overrun;

  int n_cmp = 0;
  int n_bad = 0;
  int tdiv = 1;
  int cyc = 0;

  always #2.5 clk = ~clk;

  uart_rx_mv #(.DATA_W(DW), .OVS(OVS), .FIFO_DEPTH(2), .SYNC_STAGES(2)) i_uart_rx_mv (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .recv_en(recv_en), .tick(tick),
    .rx(rx), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_ferr(out_ferr), .rx_irq(rx_irq), .overrun(overrun)
  );

  initial begin : tick_gen
    int ph;
    ph = 0;
    forever begin
      @(posedge clk);
      #1;
      if (tdiv <= 0) tick = 1'b0;
      else begin
        ph = (ph + 1 >= tdiv) ? 0 : ph + 1;
        tick = (ph == 0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
      rx = 1'b1;
    end
  endtask

  // Frame: slot 0 start, slots 1..8 data LSB first, slot 9 stop.
  // gl[b] inverts slot b at offset 9 only (middle vote sample), tdiv==1 only.
  task automatic send_frame(input logic [7:0] d, input logic stop, input logic [9:0] gl,
                            input bit lat);
    int bc;
    bc = OVS * ((tdiv <= 0) ? 1 : tdiv);
    for (int j = 0; j < 10 * bc; j++) begin
      int b;
      int off;
      logic v;
      b = j / bc;
      off = j % bc;
      @(posedge clk);
      #1;
      if (b == 0) v = 1'b0;
      else if (b == 9) v = stop;
      else v = d[b-1];
      if (gl[b] && off == 9 && tdiv == 1) v = ~v;
      rx = v;
      if (lat && j == 156) check("R5 out_valid before store edge", {31'd0, out_valid}, 32'd0);
      if (lat && j == 157) check("R5 out_valid after store edge", {31'd0, out_valid}, 32'd1);
    end
    idle(4);
  endtask

  task automatic pop_expect(input string tag, input logic [7:0] d, input logic fe);
    check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    check({tag, " data"}, {24'd0, out_data}, {24'd0, d});
    check({tag, " ferr"}, {31'd0, out_ferr}, {31'd0, fe});
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    out_ready = 1'b0;
  endtask

  task automatic low_pulse(input int n);
    for (int j = 0; j < n; j++) begin
      @(posedge clk);
      #1;
      rx = 1'b0;
    end
    idle(200);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset rx_irq", {31'd0, rx_irq}, 32'd0);
    check("R1 reset overrun", {31'd0, overrun}, 32'd0);
    rst_n = 1'b1;
    idle(2);
    check("R1 after reset out_valid", {31'd0, out_valid}, 32'd0);
    port_en = 1'b1;
    recv_en = 1'b1;
    idle(4);

    // R3 R4 R5: all byte values, clean frames
    for (int v = 0; v < 256; v++) begin
      send_frame(8'(v), 1'b1, 10'h000, v == 0);
      pop_expect("R3 sweep", 8'(v), 1'b0);
    end

    // R3: one disturbed sample in every slot
    for (int k = 0; k < 32; k++) begin
      send_frame(8'(k * 8 + 3), 1'b1, 10'h3FF, 1'b0);
      pop_expect("R3 glitch", 8'(k * 8 + 3), 1'b0);
    end

    // R4: low stop bit
    for (int k = 0; k < 16; k++) begin
      send_frame(8'(k * 17), 1'b0, 10'h000, 1'b0);
      pop_expect("R4 framing", 8'(k * 17), 1'b1);
    end

    // R2: false starts and the vote boundary
    low_pulse(4);
    check("R2 short low no entry", {31'd0, out_valid}, 32'd0);
    check("R2 short low no overrun", {31'd0, overrun}, 32'd0);
    low_pulse(9);
    check("R2 one low sample no entry", {31'd0, out_valid}, 32'd0);
    low_pulse(10);
    pop_expect("R2 two low samples start", 8'hFF, 1'b0);

    // R6 R7 R8: fill the queue, overflow, back-pressure
    send_frame(8'h11, 1'b1, 10'h000, 1'b0);
    check("R6 irq with one entry", {31'd0, rx_irq}, 32'd1);
    send_frame(8'h22, 1'b0, 10'h000, 1'b0);
    check("R7 head held under back-pressure", {24'd0, out_data}, 32'h11);
    check("R8 no overrun at two", {31'd0, overrun}, 32'd0);
    send_frame(8'h33, 1'b1, 10'h000, 1'b0);
    check("R8 overrun on third", {31'd0, overrun}, 32'd1);
    pop_expect("R7 oldest first", 8'h11, 1'b0);
    pop_expect("R7 second entry", 8'h22, 1'b1);
    check("R8 dropped char absent", {31'd0, out_valid}, 32'd0);
    check("R6 irq low when empty", {31'd0, rx_irq}, 32'd0);

    // R9: sticky until recv_en low
    port_en = 1'b0;
    idle(2);
    check("R9 port_en low keeps overrun", {31'd0, overrun}, 32'd1);
    port_en = 1'b1;
    recv_en = 1'b0;
    @(posedge clk);
    #1;
    recv_en = 1'b1;
    check("R9 overrun cleared", {31'd0, overrun}, 32'd0);
    idle(4);

    // R10: disabled receiver ignores the line, queued data stays
    send_frame(8'h44, 1'b1, 10'h000, 1'b0);
    port_en = 1'b0;
    send_frame(8'h55, 1'b1, 10'h000, 1'b0);
    check("R10 queued head kept", {24'd0, out_data}, 32'h44);
    pop_expect("R10 queued entry", 8'h44, 1'b0);
    check("R10 port_en low no entry", {31'd0, out_valid}, 32'd0);
    port_en = 1'b1;
    recv_en = 1'b0;
    send_frame(8'h66, 1'b1, 10'h000, 1'b0);
    check("R10 recv_en low no entry", {31'd0, out_valid}, 32'd0);
    recv_en = 1'b1;
    idle(4);

    // R11: slow tick and stopped tick
    tdiv = 3;
    idle(4);
    send_frame(8'h3C, 1'b1, 10'h000, 1'b0);
    pop_expect("R11 tick every third", 8'h3C, 1'b0);
    send_frame(8'hC3, 1'b0, 10'h000, 1'b0);
    pop_expect("R11 tick every third ferr", 8'hC3, 1'b1);
    tdiv = 0;
    idle(2);
    send_frame(8'h81, 1'b1, 10'h000, 1'b0);
    idle(100);
    check("R11 no tick no entry", {31'd0, out_valid}, 32'd0);
    port_en = 1'b0;
    idle(2);
    port_en = 1'b1;
    tdiv = 1;
    idle(4);
    send_frame(8'h5A, 1'b1, 10'h000, 1'b0);
    pop_expect("R11 recovers after restart", 8'h5A, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule